// File: doc/BRIEF.md
# Partitioned Fixed-Point SIMD Lane ALU

This block is one 64-bit lane of a packed-subword arithmetic unit. A single operation treats the lane as one 64-bit element, two 32-bit elements, four 16-bit elements or eight 8-bit elements. The element width is chosen per operation. The ALU performs add, subtract, fixed-point multiply, and fixed-point multiply-accumulate. Results can be signed or unsigned, and can either wrap or saturate. The multiply keeps the product scaled down by half the element width and rounds it in one of three selectable ways. Four identical lanes placed side by side form a 256-bit unit.

Each operation carries two source words, a scalar word and the current destination word. The operand form can replace either source with the low element of the scalar, copied into every element position. A per-element enable mask implements conditional execution. A disabled element passes the destination value through unchanged. The destination word also supplies the addend for multiply-accumulate. The result word comes out with per-element clamp flags, and a sticky copy of those flags is kept until reset.

Operations enter and results leave through valid/ready streams. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its flags hold still. The stall then moves back into the pipeline, and `in_ready` falls once the internal stage is also occupied. Control fields ride along with their data and have no handshake of their own.

Top module: `fxl_lane_alu`

## Requirements
- R1: Width code k (in_wsel) selects elements of 8<<k bits: 0=8, 1=16, 2=32, 3=64. Element i occupies bits [i*W +: W] and reports in flag bit i. Carries and borrows never cross an element boundary. Flag bits at or above the element count stay 0.
- R2: in_op 0 adds and in_op 1 subtracts (a minus b). With in_sat=0, each element wraps modulo 2^W and its flag stays 0.
- R3: With in_sat=1, an out-of-range element is clamped and its flag bit is set. In signed mode (in_signed=1) the clamp limits are -2^(W-1) and 2^(W-1)-1. In unsigned mode they are 0 and 2^W-1.
- R4: in_op 2 multiplies the elements as full-precision integers and shifts the product right by W/2 with rounding. in_rnd selects the rounding: 0 truncates toward minus infinity. 1 rounds a discarded half upward. 2 rounds a discarded half to the even kept value. 3 behaves as 0.
- R5: in_op 3 forms the rounded, scaled product as in R4, adds the destination element in_dest, and then wraps or saturates as in R2 and R3.
- R6: in_form selects the operand form. Form 0 uses both vectors. Form 1 replaces b with the low W bits of in_scalar in every element. Form 2 replaces a the same way. Form 3 behaves as 0.
- R7: An element with in_mask[i]=0 outputs its in_dest element unchanged and reports flag 0.
- R8: An operation accepted on one edge appears on out_valid/out_data after the following edge, two register stages later. Accepted operations may arrive on consecutive cycles and leave in order, one per cycle.
- R9: While out_valid is high and out_ready is low, out_data and out_sat hold. in_ready drops once the internal stage is also full.
- R10: sat_sticky is the OR of the out_sat values of every result produced since reset. It never clears except by reset.
- R11: After reset, out_valid=0, in_ready=1 and sat_sticky=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 2 | 0 add, 1 sub, 2 mul, 3 mul-acc |
| in_wsel | input | 2 | Element width code |
| in_rnd | input | 2 | Rounding mode for multiply |
| in_form | input | 2 | Operand form (vector/scalar) |
| in_signed | input | 1 | Signed element interpretation |
| in_sat | input | 1 | Saturate instead of wrap |
| in_mask | input | LANE_W/8 | Per-element enable |
| in_a | input | LANE_W | First source vector |
| in_b | input | LANE_W | Second source vector |
| in_scalar | input | LANE_W | Scalar; low W bits broadcast |
| in_dest | input | LANE_W | Old destination / accumulator |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANE_W | Result word |
| out_sat | output | LANE_W/8 | Per-element clamp flags of this result |
| sat_sticky | output | LANE_W/8 | Accumulated clamp flags |

## Verification
The assertions check, on every cycle, the rules that need no arithmetic: a stalled result holding, `in_ready` falling when both stages are full, sticky flags never falling, and no clamp flag appearing for a disabled element or for a position beyond the element count. The arithmetic itself (wrap and clamp values, the scaled product under each rounding mode, accumulation, broadcast of the scalar, and carry isolation at each width) can only be shown by the bench's sweeps. Those sweeps cover every width, operation, signedness, saturation and rounding setting against an independent model. Latency, ordering under back-to-back issue, and recovery after a stall are shown by directed scenarios.

// File: rtl/fxl_pkg.sv
package fxl_pkg;
  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_SUB = 2'd1;
  localparam logic [1:0] OP_MUL = 2'd2;
  localparam logic [1:0] OP_MAC = 2'd3;

  localparam logic [1:0] RND_TRUNC = 2'd0;
  localparam logic [1:0] RND_HUP   = 2'd1;
  localparam logic [1:0] RND_EVEN  = 2'd2;

  localparam logic [1:0] FORM_VV = 2'd0;
  localparam logic [1:0] FORM_VS = 2'd1;
  localparam logic [1:0] FORM_SV = 2'd2;

  localparam int NWID = 4;      // number of selectable element widths
  localparam int MIN_EW = 8;    // narrowest element

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] wsel;
    logic [1:0] rnd;
    logic       sgn;
    logic       sat;
  } fxl_ctrl_t;
endpackage

// File: rtl/fxl_elem.sv
// One element of width W: add / sub / scaled multiply / multiply-accumulate.
module fxl_elem import fxl_pkg::*; #(
  parameter int W = 8
) (
  input  logic [1:0]   op,
  input  logic [1:0]   rnd,
  input  logic         sgn,
  input  logic         sat,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] d,
  output logic [W-1:0] y,
  output logic         clamp
);
  localparam int EW = 2*W + 2;
  localparam int F  = W / 2;
  localparam logic signed [EW-1:0] ONE  = 1;
  localparam logic signed [EW-1:0] SMAX = (ONE <<< (W-1)) - ONE;
  localparam logic signed [EW-1:0] SMIN = ~SMAX;
  localparam logic signed [EW-1:0] UMAX = (ONE <<< W) - ONE;
  localparam logic signed [EW-1:0] UMIN = '0;

  logic signed [EW-1:0] ea, eb, ed, prod, q, inc_s, r, hi, lo;
  logic inc;

  always_comb begin
    ea = sgn ? {{(EW-W){a[W-1]}}, a} : {{(EW-W){1'b0}}, a};
    eb = sgn ? {{(EW-W){b[W-1]}}, b} : {{(EW-W){1'b0}}, b};
    ed = sgn ? {{(EW-W){d[W-1]}}, d} : {{(EW-W){1'b0}}, d};
    prod = ea * eb;
    q = prod >>> F;
    case (rnd)
      RND_HUP:  inc = prod[F-1];
      RND_EVEN: inc = prod[F-1] & ((|prod[F-2:0]) | prod[F]);
      default:  inc = 1'b0;
    endcase
    inc_s = $signed({{(EW-1){1'b0}}, inc});
    case (op)
      OP_ADD:  r = ea + eb;
      OP_SUB:  r = ea - eb;
      OP_MUL:  r = q + inc_s;
      default: r = q + inc_s + ed;
    endcase
    hi = sgn ? SMAX : UMAX;
    lo = sgn ? SMIN : UMIN;
    clamp = 1'b0;
    y = r[W-1:0];
    if (sat && (r > hi)) begin
      y = hi[W-1:0];
      clamp = 1'b1;
    end else if (sat && (r < lo)) begin
      y = lo[W-1:0];
      clamp = 1'b1;
    end
  end
endmodule

// File: rtl/fxl_slice.sv
// All elements of one width across the lane, with mask merge.
module fxl_slice import fxl_pkg::*; #(
  parameter int LANE_W = 64,
  parameter int EWD    = 8,
  localparam int NE    = LANE_W / EWD
) (
  input  logic [1:0]        op,
  input  logic [1:0]        rnd,
  input  logic              sgn,
  input  logic              sat,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] d,
  input  logic [NE-1:0]     mask,
  output logic [LANE_W-1:0] y,
  output logic [NE-1:0]     flg
);
  for (genvar i = 0; i < NE; i++) begin : g_el
    logic [EWD-1:0] ey;
    logic           ec;
    fxl_elem #(.W(EWD)) u_el (
      .op(op), .rnd(rnd), .sgn(sgn), .sat(sat),
      .a(a[i*EWD +: EWD]), .b(b[i*EWD +: EWD]), .d(d[i*EWD +: EWD]),
      .y(ey), .clamp(ec)
    );
    assign y[i*EWD +: EWD] = mask[i] ? ey : d[i*EWD +: EWD];
    assign flg[i]          = mask[i] & ec;
  end
endmodule

// File: rtl/fxl_bcast.sv
// Operand-form selection: replicate the scalar's low element where asked.
module fxl_bcast import fxl_pkg::*; #(
  parameter int LANE_W = 64
) (
  input  logic [1:0]        wsel,
  input  logic [1:0]        form,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] s,
  output logic [LANE_W-1:0] a_o,
  output logic [LANE_W-1:0] b_o
);
  logic [LANE_W-1:0] rep [NWID];
  logic [LANE_W-1:0] sr;

  for (genvar k = 0; k < NWID; k++) begin : g_rep
    localparam int EWD = MIN_EW << k;
    localparam int NE  = LANE_W / EWD;
    assign rep[k] = {NE{s[EWD-1:0]}};
  end

  always_comb begin
    sr  = rep[wsel];
    a_o = (form == FORM_SV) ? sr : a;
    b_o = (form == FORM_VS) ? sr : b;
  end
endmodule

// File: rtl/fxl_lane_alu.sv
module fxl_lane_alu import fxl_pkg::*; #(
  parameter int LANE_W = 64,
  localparam int MAXE  = LANE_W / MIN_EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [1:0]        in_wsel,
  input  logic [1:0]        in_rnd,
  input  logic [1:0]        in_form,
  input  logic              in_signed,
  input  logic              in_sat,
  input  logic [MAXE-1:0]   in_mask,
  input  logic [LANE_W-1:0] in_a,
  input  logic [LANE_W-1:0] in_b,
  input  logic [LANE_W-1:0] in_scalar,
  input  logic [LANE_W-1:0] in_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANE_W-1:0] out_data,
  output logic [MAXE-1:0]   out_sat,
  output logic [MAXE-1:0]   sat_sticky
);
  // ---------------- stage 1: operand formation and capture
  logic [LANE_W-1:0] fa, fb;
  fxl_bcast #(.LANE_W(LANE_W)) u_bcast (
    .wsel(in_wsel), .form(in_form), .a(in_a), .b(in_b), .s(in_scalar),
    .a_o(fa), .b_o(fb)
  );

  logic              s1_valid;
  fxl_ctrl_t         s1_ctrl;
  logic [MAXE-1:0]   s1_mask;
  logic [LANE_W-1:0] s1_a, s1_b, s1_d;
  logic              s1_ready, s2_ready;

  assign s2_ready = !out_valid || out_ready;
  assign s1_ready = !s1_valid || s2_ready;
  assign in_ready = s1_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctrl  <= '0;
      s1_mask  <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_d     <= '0;
    end else if (s1_ready) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ctrl <= '{op: in_op, wsel: in_wsel, rnd: in_rnd,
                     sgn: in_signed, sat: in_sat};
        s1_mask <= in_mask;
        s1_a    <= fa;
        s1_b    <= fb;
        s1_d    <= in_dest;
      end
    end
  end

  // ---------------- stage 2: per-width datapaths, width select
  logic [LANE_W-1:0] y_k   [NWID];
  logic [MAXE-1:0]   flg_k [NWID];
  logic [MAXE-1:0]   live_k[NWID];

  for (genvar k = 0; k < NWID; k++) begin : g_wid
    localparam int EWD = MIN_EW << k;
    localparam int NE  = LANE_W / EWD;
    logic [NE-1:0] fl;
    fxl_slice #(.LANE_W(LANE_W), .EWD(EWD)) u_slice (
      .op(s1_ctrl.op), .rnd(s1_ctrl.rnd), .sgn(s1_ctrl.sgn), .sat(s1_ctrl.sat),
      .a(s1_a), .b(s1_b), .d(s1_d), .mask(s1_mask[NE-1:0]),
      .y(y_k[k]), .flg(fl)
    );
    assign flg_k[k]  = MAXE'(fl);
    assign live_k[k] = MAXE'({NE{1'b1}});
  end

  logic [LANE_W-1:0] y_sel;
  logic [MAXE-1:0]   f_sel;
  always_comb begin
    y_sel = y_k[s1_ctrl.wsel];
    f_sel = flg_k[s1_ctrl.wsel];
  end

  logic [1:0]      s2_wsel;
  logic [MAXE-1:0] s2_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sat    <= '0;
      sat_sticky <= '0;
      s2_wsel    <= '0;
      s2_mask    <= '0;
    end else if (s2_ready) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data   <= y_sel;
        out_sat    <= f_sel;
        sat_sticky <= sat_sticky | f_sel;
        s2_wsel    <= s1_ctrl.wsel;
        s2_mask    <= s1_mask;
      end
    end
  end

  // ---------------- assertions
  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));

  // R9
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sat_sticky & $past(sat_sticky)) == $past(sat_sticky)));

  // R7
  masked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sat & ~s2_mask) == '0));

  // R1
  flag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sat & ~live_k[s2_wsel]) == '0));
endmodule

// File: tb/fxl_lane_alu_test.sv
`timescale 1ns/1ps
module fxl_lane_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0, in_wsel = '0, in_rnd = '0, in_form = '0;
  logic        in_signed = 1'b0, in_sat = 1'b0;
  logic [7:0]  in_mask = '0;
  logic [63:0] in_a = '0, in_b = '0, in_scalar = '0, in_dest = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_sat, sat_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  exp_sticky = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  fxl_lane_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wsel(in_wsel), .in_rnd(in_rnd), .in_form(in_form),
    .in_signed(in_signed), .in_sat(in_sat), .in_mask(in_mask),
    .in_a(in_a), .in_b(in_b), .in_scalar(in_scalar), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sat(out_sat), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] rnd64();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic signed [129:0] ext(input logic [63:0] x, input int w, input bit sgn);
    logic signed [129:0] v;
    v = $signed({66'd0, x & wmask(w)});
    if (sgn && x[w-1]) v = v - (130'sd1 <<< w);
    return v;
  endfunction

  task automatic elem_model(input logic [1:0] op, input logic [1:0] rnd, input int w,
                            input bit sgn, input bit sat,
                            input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                            output logic [63:0] y, output bit fl);
    logic signed [129:0] ea, eb, ed, p, q, rem, half, r, hi, lo;
    int f;
    ea = ext(a, w, sgn); eb = ext(b, w, sgn); ed = ext(d, w, sgn);
    f = w / 2;
    if (op == 2'd0) r = ea + eb;
    else if (op == 2'd1) r = ea - eb;
    else begin
      p = ea * eb;
      q = p >>> f;
      rem = p - (q <<< f);
      half = 130'sd1 <<< (f - 1);
      r = q;
      if (rnd == 2'd1 && rem >= half) r = q + 1;
      if (rnd == 2'd2 && (rem > half || (rem == half && q[0]))) r = q + 1;
      if (op == 2'd3) r = r + ed;
    end
    hi = sgn ? ((130'sd1 <<< (w-1)) - 1) : ((130'sd1 <<< w) - 1);
    lo = sgn ? -(130'sd1 <<< (w-1)) : 130'sd0;
    fl = 1'b0;
    if (sat && r > hi) begin r = hi; fl = 1'b1; end
    else if (sat && r < lo) begin r = lo; fl = 1'b1; end
    y = r[63:0] & wmask(w);
  endtask

  task automatic lane_model(input logic [1:0] op, input logic [1:0] wsel, input logic [1:0] rnd,
                            input logic [1:0] form, input bit sgn, input bit sat,
                            input logic [7:0] mask, input logic [63:0] a, input logic [63:0] b,
                            input logic [63:0] s, input logic [63:0] d,
                            output logic [63:0] y, output logic [7:0] fl);
    int w, ne;
    logic [63:0] ai, bi, di, ye;
    bit fe;
    w = 8 << wsel;
    ne = 64 / w;
    y = '0; fl = '0;
    for (int i = 0; i < ne; i++) begin
      ai = (form == 2'd2) ? s : (a >> (i*w));
      bi = (form == 2'd1) ? s : (b >> (i*w));
      di = d >> (i*w);
      elem_model(op, rnd, w, sgn, sat, ai, bi, di, ye, fe);
      if (mask[i]) begin
        y = y | ((ye & wmask(w)) << (i*w));
        fl[i] = fe;
      end else begin
        y = y | ((di & wmask(w)) << (i*w));
      end
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] wsel, input logic [1:0] rnd,
                       input logic [1:0] form, input bit sgn, input bit sat, input logic [7:0] mask,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
                       input logic [63:0] d);
    in_op = op; in_wsel = wsel; in_rnd = rnd; in_form = form;
    in_signed = sgn; in_sat = sat; in_mask = mask;
    in_a = a; in_b = b; in_scalar = s; in_dest = d;
    in_valid = 1'b1;
  endtask

  // One isolated operation; checks against model and optionally a literal.
  task automatic run_op(input string tag, input logic [1:0] op, input logic [1:0] wsel,
                        input logic [1:0] rnd, input logic [1:0] form, input bit sgn, input bit sat,
                        input logic [7:0] mask, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] s, input logic [63:0] d,
                        input bit use_lit, input logic [63:0] lit_y, input logic [7:0] lit_f);
    logic [63:0] ey;
    logic [7:0]  ef;
    lane_model(op, wsel, rnd, form, sgn, sat, mask, a, b, s, d, ey, ef);
    if (use_lit) begin ey = lit_y; ef = lit_f; end
    @(posedge clk); #1;
    drive(op, wsel, rnd, form, sgn, sat, mask, a, b, s, d);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " data"}, out_data, ey);
    chk({tag, " flags"}, 64'(out_sat), 64'(ef));
    exp_sticky = exp_sticky | ef;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] y1, y2, y3;
    logic [7:0]  f1, f2, f3;
    logic [63:0] held;
    logic [63:0] pa, pb;

    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    chk("R11 in_ready", 64'(in_ready), 64'd1);
    chk("R11 sticky", 64'(sat_sticky), 64'd0);
    rst_n = 1'b1;

    // R1 R2: carry isolation at 8 bits, unsigned wrap
    run_op("R1 carry stop", 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 8'hFF,
           64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, '0, '0, 1, 64'h0, 8'h00);
    // R1: 16-bit borrow stays inside element
    run_op("R1 borrow stop", 2'd1, 2'd1, 2'd0, 2'd0, 0, 0, 8'hFF,
           64'h0000_1000_0000_0005, 64'h0001_0000_0001_0000, '0, '0, 1,
           64'hFFFF_1000_FFFF_0005, 8'h00);
    // R2: signed wrap without saturation
    run_op("R2 wrap", 2'd0, 2'd0, 2'd0, 2'd0, 1, 0, 8'hFF,
           64'h7F, 64'h01, '0, '0, 1, 64'h80, 8'h00);
    // R3: signed clamp high
    run_op("R3 signed hi", 2'd0, 2'd0, 2'd0, 2'd0, 1, 1, 8'hFF,
           64'h7F, 64'h01, '0, '0, 1, 64'h7F, 8'h01);
    // R3: unsigned clamp low in all 16-bit elements
    run_op("R3 unsigned lo", 2'd1, 2'd1, 2'd0, 2'd0, 0, 1, 8'hFF,
           64'h0, 64'h0001_0001_0001_0001, '0, '0, 1, 64'h0, 8'h0F);
    // R4: rounding of an exact half, kept lsb even (1*8/16 = 0.5)
    run_op("R4 trunc", 2'd2, 2'd0, 2'd0, 2'd0, 1, 0, 8'h01, 64'h01, 64'h08, '0, '0, 1, 64'h00, 8'h00);
    run_op("R4 half up", 2'd2, 2'd0, 2'd1, 2'd0, 1, 0, 8'h01, 64'h01, 64'h08, '0, '0, 1, 64'h01, 8'h00);
    run_op("R4 half even 0.5", 2'd2, 2'd0, 2'd2, 2'd0, 1, 0, 8'h01, 64'h01, 64'h08, '0, '0, 1, 64'h00, 8'h00);
    // R4: 3*8/16 = 1.5, even goes to 2
    run_op("R4 half even 1.5", 2'd2, 2'd0, 2'd2, 2'd0, 1, 0, 8'h01, 64'h03, 64'h08, '0, '0, 1, 64'h02, 8'h00);
    // R5: 16-bit Q8 1.0*2.0 + 5
    run_op("R5 mac", 2'd3, 2'd1, 2'd0, 2'd0, 1, 0, 8'h01, 64'h0100, 64'h0200, '0, 64'h0005, 1,
           64'h0205, 8'h00);
    // R6: vector-scalar and scalar-vector forms at 32 bits
    run_op("R6 vs", 2'd0, 2'd2, 2'd0, 2'd1, 0, 0, 8'h03, {32'h10, 32'h20}, '0,
           64'hFFFF_FFFF_0000_0003, '0, 1, {32'h13, 32'h23}, 8'h00);
    run_op("R6 sv", 2'd1, 2'd2, 2'd0, 2'd2, 0, 0, 8'h03, '0, {32'h1, 32'h2},
           64'h0000_0000_0000_0100, '0, 1, {32'hFF, 32'hFE}, 8'h00);
    // R7: masked elements keep destination, no flags from them
    run_op("R7 mask keep", 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 8'h0F, 64'h0101_0101_0101_0101,
           64'h0101_0101_0101_0101, '0, 64'hAAAA_AAAA_AAAA_AAAA, 1, 64'hAAAA_AAAA_0202_0202, 8'h00);
    run_op("R7 mask flag", 2'd0, 2'd0, 2'd0, 2'd0, 1, 1, 8'h01, 64'h7F7F_7F7F_7F7F_7F7F,
           64'h0101_0101_0101_0101, '0, '0, 1, 64'h0000_0000_0000_007F, 8'h01);

    // Sweep: every width, op, sign, saturation, rounding, several patterns (R1-covering)
    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 4; op++)
        for (int sg = 0; sg < 2; sg++)
          for (int st = 0; st < 2; st++)
            for (int rn = 0; rn < 3; rn++)
              for (int pt = 0; pt < 4; pt++) begin
                case (pt)
                  0: begin pa = rnd64(); pb = rnd64(); end
                  1: begin pa = 64'h7F80_FF00_7FFF_8001; pb = rnd64(); end
                  2: begin pa = '1; pb = rnd64(); end
                  default: begin pa = rnd64(); pb = 64'h8000_0000_8000_8080; end
                endcase
                run_op("R1 R2 R3 R4 R5 R6 R7 sweep", 2'(op), 2'(w), 2'(rn), 2'(pt % 3),
                       sg[0], st[0], (pt == 0) ? 8'hFF : rnd64()[7:0],
                       pa, pb, rnd64(), rnd64(), 0, '0, '0);
              end

    // R8: latency and back-to-back ordering
    lane_model(2'd0, 2'd0, 2'd0, 2'd0, 0, 1, 8'hFF, 64'h11, 64'h22, '0, '0, y1, f1);
    lane_model(2'd2, 2'd1, 2'd1, 2'd0, 1, 1, 8'hFF, 64'h7FFF_8000, 64'h7FFF_7FFF, '0, '0, y2, f2);
    lane_model(2'd1, 2'd3, 2'd0, 2'd0, 1, 1, 8'hFF, 64'h8000_0000_0000_0000, 64'h1, '0, '0, y3, f3);
    @(posedge clk); #1;
    drive(2'd0, 2'd0, 2'd0, 2'd0, 0, 1, 8'hFF, 64'h11, 64'h22, '0, '0);
    @(posedge clk); #1;
    chk("R8 not early", 64'(out_valid), 64'd0);
    drive(2'd2, 2'd1, 2'd1, 2'd0, 1, 1, 8'hFF, 64'h7FFF_8000, 64'h7FFF_7FFF, '0, '0);
    @(posedge clk); #1;
    chk("R8 first", out_data, y1);
    chk("R8 first valid", 64'(out_valid), 64'd1);
    drive(2'd1, 2'd3, 2'd0, 2'd0, 1, 1, 8'hFF, 64'h8000_0000_0000_0000, 64'h1, '0, '0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R8 second", out_data, y2);
    chk("R8 second flags", 64'(out_sat), 64'(f2));
    @(posedge clk); #1;
    chk("R8 third", out_data, y3);
    chk("R8 third flags", 64'(out_sat), 64'(f3));
    exp_sticky = exp_sticky | f1 | f2 | f3;
    @(posedge clk); #1;
    chk("R8 drained", 64'(out_valid), 64'd0);

    // R9: back-pressure
    out_ready = 1'b0;
    lane_model(2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 8'hFF, 64'h0102_0304_0506_0708, 64'h1, '0, '0, y1, f1);
    lane_model(2'd1, 2'd1, 2'd0, 2'd0, 0, 0, 8'hFF, 64'h0009_0009_0009_0009, 64'h1, '0, '0, y2, f2);
    drive(2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 8'hFF, 64'h0102_0304_0506_0708, 64'h1, '0, '0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 first out", out_data, y1);
    held = out_data;
    drive(2'd1, 2'd1, 2'd0, 2'd0, 0, 0, 8'hFF, 64'h0009_0009_0009_0009, 64'h1, '0, '0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R9 in_ready low", 64'(in_ready), 64'd0);
    chk("R9 held", out_data, held);
    @(posedge clk); #1;
    chk("R9 still held", out_data, y1);
    chk("R9 still valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R9 next out", out_data, y2);
    chk("R9 ready back", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    chk("R9 drained", 64'(out_valid), 64'd0);

    // R10: sticky is the OR of all flags seen, and survives a clean op
    run_op("R10 clean op", 2'd0, 2'd0, 2'd0, 2'd0, 0, 0, 8'hFF, 64'h1, 64'h1, '0, '0, 0, '0, '0);
    @(posedge clk); #1;
    chk("R10 sticky", 64'(sat_sticky), 64'(exp_sticky));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule